// File: doc/BRIEF.md
# Root Port Interrupt Status Aggregator

This block collects up to 32 interrupt sources belonging to one root port into a single status word. It combines them, under a per-source mask, into one interrupt line for a parent controller. The four lowest sources are the legacy wired interrupts A to D, which are level signals. Every other source is a one-shot event that the block latches on its rising edge and holds until software clears it. The upper sources carry link and error events: port error and the advanced-error group at 4 to 7, link up at 12, link down at 14, completion timeout at 23, and others. The block treats all of the upper sources alike.

Software reaches the block through a small word-addressed register bus. It reads the status and mask words. It changes the mask only through two write-only aliases: one sets mask bits and one clears them. It acknowledges edge events by writing ones to the status word. The combined interrupt output is registered. It is high whenever some status bit is set while its mask bit is clear.

Top module: `port_irq_agg`

## Requirements
- R1: After a synchronous reset the status word is all zeros, the mask word is all ones, `irq_out` is low and `rsp_rdata` is zero.
- R2: `req_addr` selects 0 = status, 1 = mask (read-only; writes are ignored), 2 = mask-set and 3 = mask-clear. Reads of 2 and 3 return zero. Read data appears on `rsp_rdata` after the clock edge that accepts the read and is held until the next read.
- R3: A write to mask-set sets every mask bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R4: A write to mask-clear clears every mask bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R5: Status bits 0 to 3 copy their `evt_in` bits one clock edge later. Writing 1 to them at address 0 has no effect.
- R6: Status bits 4 and above are set by a rising edge: the input is low at one clock edge and high at the next. They then stay set whatever the input does. An input held high does not set the bit again after it is cleared.
- R7: A write to address 0 clears each edge status bit written with 1 and leaves the bits written with 0 unchanged.
- R8: When a rising edge and a clearing write reach the same edge status bit in the same cycle, the bit stays set.
- R9: `irq_out` is the registered OR of status AND NOT mask. It changes one clock edge after the status or mask change that causes it.
- R10: Writing all ones to mask-set and then all ones to status leaves the mask all ones and every edge status bit zero. The level status bits still follow their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_SRC | Source inputs; bits 0-3 are levels, the rest are edge events |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | NUM_SRC | Write data |
| rsp_rdata | output | NUM_SRC | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions take `evt_in` and all of the bus request inputs to be 0 or 1 and stable from one clock edge to the next. They assume at least two reset cycles, so that the history sampled in the first cycle after reset comes from registers that are already reset. The rising-edge check also assumes the edge inputs are low while reset is held, because the block's edge history starts at zero. The bench holds every input at zero through reset. It changes inputs and bus fields only on falling clock edges, and each bus request lasts exactly one cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_MSET = 2'd2,
    REG_MCLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] status
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_LVL) begin : g_level
      // level source: tracks its input, acknowledge writes are ignored (R5)
      always_ff @(posedge clk) begin
        if (rst) status[i] <= 1'b0;
        else     status[i] <= evt_in[i];
      end
    end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q    <= 1'b0;
          status[i] <= 1'b0;
        end else begin
          prev_q    <= evt_in[i];
          // new edge is OR-ed after the clear so it wins (R8)
          status[i] <= (status[i] & ~clr_vec[i]) | (evt_in[i] & ~prev_q);
        end
      end
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else     mask <= (mask | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_addr,
  input  logic [NUM_SRC-1:0] req_wdata,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] stat_clr,
  output logic [NUM_SRC-1:0] mask_set,
  output logic [NUM_SRC-1:0] mask_clr,
  output logic [NUM_SRC-1:0] rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(req_addr);

  always_comb begin
    stat_clr = '0;
    mask_set = '0;
    mask_clr = '0;
    if (req_valid && req_write) begin
      case (sel)
        REG_STAT: stat_clr = req_wdata;
        REG_MSET: mask_set = req_wdata;
        REG_MCLR: mask_clr = req_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (req_valid && !req_write) begin
      case (sel)
        REG_STAT: rdata <= status;
        REG_MASK: rdata <= mask;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/port_irq_agg.sv
module port_irq_agg #(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_addr,
  input  logic [NUM_SRC-1:0] req_wdata,
  output logic [NUM_SRC-1:0] rsp_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] stat_clr;
  logic [NUM_SRC-1:0] mask_set;
  logic [NUM_SRC-1:0] mask_clr;

  irq_bus_port #(.NUM_SRC(NUM_SRC)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .status    (stat_q),
    .mask      (mask_q),
    .stat_clr  (stat_clr),
    .mask_set  (mask_set),
    .mask_clr  (mask_clr),
    .rdata     (rsp_rdata)
  );

  irq_src_bank #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_src (
    .clk     (clk),
    .rst     (rst),
    .evt_in  (evt_in),
    .clr_vec (stat_clr),
    .status  (stat_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .set_vec (mask_set),
    .clr_vec (mask_clr),
    .mask    (mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(stat_q & ~mask_q);
  end
endmodule

// File: rtl/port_irq_agg_chk.sv
module port_irq_agg_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_in,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_addr,
  input logic [NUM_SRC-1:0] req_wdata,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask,
  input logic               irq_out
);
  localparam logic [NUM_SRC-1:0] LVL_SEL  = {{(NUM_SRC-NUM_LVL){1'b0}}, {NUM_LVL{1'b1}}};
  localparam logic [NUM_SRC-1:0] EDGE_SEL = ~LVL_SEL;

  logic               wr_stat, wr_mset, wr_mclr;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] evt_q;
  logic [NUM_SRC-1:0] rise;

  assign wr_stat = req_valid && req_write && (req_addr == 2'd0);
  assign wr_mset = req_valid && req_write && (req_addr == 2'd2);
  assign wr_mclr = req_valid && req_write && (req_addr == 2'd3);
  assign ack_vec = wr_stat ? req_wdata : '0;
  assign rise    = evt_in & ~evt_q & EDGE_SEL;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_in;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (status == '0) && (mask == '1) && !irq_out);

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
    wr_mset |=> ((mask & $past(req_wdata)) == $past(req_wdata)));

  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
    wr_mclr |=> ((mask & $past(req_wdata)) == '0));

  // R2: the mask only changes through the set and clear aliases
  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_mset || wr_mclr) |=> (mask == $past(mask)));

  assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & LVL_SEL) == ($past(evt_in) & LVL_SEL)));

  assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(status & ~ack_vec) & EDGE_SEL) ==
              ($past(status & ~ack_vec) & EDGE_SEL)));

  // R8: an edge always lands, even against a clearing write
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rise) & ~status) == '0));

  assert_irq_combine_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(status & ~mask))));
endmodule

bind port_irq_agg port_irq_agg_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_in    (evt_in),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .status    (stat_q),
  .mask      (mask_q),
  .irq_out   (irq_out)
);

// File: tb/port_irq_agg_tb.sv
module port_irq_agg_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_in = '0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [1:0]   req_addr = 2'd0;
  logic [N-1:0] req_wdata = '0;
  logic [N-1:0] rsp_rdata;
  logic         irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  port_irq_agg #(.NUM_SRC(N), .NUM_LVL(4)) u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [N-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [N-1:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    evt_in = evt_in | bits;
    @(negedge clk);
    evt_in = evt_in & ~bits;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R1 rdata after reset", rsp_rdata, '0);
    check("R1 irq_out after reset", {31'd0, irq_out}, '0);
    bus_rd(2'd0, v); check("R1 status after reset", v, '0);
    bus_rd(2'd1, v); check("R1 mask after reset", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    bus_wr(2'd3, 32'h0000_F0F0);
    bus_rd(2'd1, v); check("R4 mask clear", v, 32'hFFFF_0F0F);
    bus_wr(2'd2, 32'h0000_0030);
    bus_rd(2'd1, v); check("R3 mask set", v, 32'hFFFF_0F3F);
    bus_wr(2'd2, 32'h0);
    bus_wr(2'd3, 32'h0);
    bus_rd(2'd1, v); check("R3 R4 zero bits no effect", v, 32'hFFFF_0F3F);
    bus_wr(2'd1, 32'h0);
    bus_rd(2'd1, v); check("R2 mask address read-only", v, 32'hFFFF_0F3F);
    bus_rd(2'd2, v); check("R2 mask-set reads zero", v, '0);
    bus_rd(2'd3, v); check("R2 mask-clear reads zero", v, '0);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    evt_in[2] = 1'b1;
    @(negedge clk);
    bus_rd(2'd0, v); check("R5 level follows high", v, 32'h4);
    bus_wr(2'd0, 32'h4);
    bus_rd(2'd0, v); check("R5 level ignores write-1", v, 32'h4);
    evt_in[2] = 1'b0;
    @(negedge clk);
    bus_rd(2'd0, v); check("R5 level follows low", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [N-1:0] v;
    pulse(32'h0000_1000);
    bus_rd(2'd0, v); check("R6 edge latched after pulse", v, 32'h0000_1000);
    bus_wr(2'd0, 32'h0000_1000);
    bus_rd(2'd0, v); check("R7 edge cleared", v, 32'h0);
    evt_in[14] = 1'b1;
    @(negedge clk);
    bus_rd(2'd0, v); check("R6 held-high edge latched", v, 32'h0000_4000);
    bus_wr(2'd0, 32'h0000_4000);
    @(negedge clk);
    bus_rd(2'd0, v); check("R6 held-high not re-set", v, 32'h0);
    evt_in[14] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_w1c();
    logic [N-1:0] v;
    pulse(32'h0030_0000);
    bus_wr(2'd0, 32'h0010_0000);
    bus_rd(2'd0, v); check("R7 selective clear", v, 32'h0020_0000);
    bus_wr(2'd0, 32'h0);
    bus_rd(2'd0, v); check("R7 zero write no effect", v, 32'h0020_0000);
    bus_wr(2'd0, 32'h0020_0000);
  endtask

  task automatic t_collision();
    logic [N-1:0] v;
    evt_in[23] = 1'b1;
    bus_wr(2'd0, 32'h0080_0000);
    evt_in[23] = 1'b0;
    bus_rd(2'd0, v); check("R8 edge beats clear", v, 32'h0080_0000);
    bus_wr(2'd0, 32'h0080_0000);
    bus_rd(2'd0, v); check("R8 later clear works", v, 32'h0);
  endtask

  task automatic t_irq();
    bus_wr(2'd2, 32'hFFFF_FFFF);
    bus_wr(2'd3, 32'h0000_1000);
    @(negedge clk);
    evt_in[12] = 1'b1;
    @(negedge clk);
    evt_in[12] = 1'b0;
    check("R9 irq one edge after status", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R9 irq asserted", {31'd0, irq_out}, 32'd1);
    bus_wr(2'd2, 32'h0000_1000);
    check("R9 irq before mask takes effect", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R9 irq masked", {31'd0, irq_out}, 32'd0);
    bus_wr(2'd3, 32'h0000_1000);
    @(negedge clk);
    check("R9 irq unmasked again", {31'd0, irq_out}, 32'd1);
    bus_wr(2'd0, 32'h0000_1000);
    @(negedge clk);
    check("R9 irq after acknowledge", {31'd0, irq_out}, 32'd0);
    pulse(32'h0000_0800);
    @(negedge clk);
    check("R9 masked source no irq", {31'd0, irq_out}, 32'd0);
    bus_wr(2'd0, 32'h0000_0800);
  endtask

  task automatic t_all();
    logic [N-1:0] v;
    evt_in[1] = 1'b1;
    pulse(32'h80C0_8010);
    bus_wr(2'd3, 32'hFFFF_FFFF);
    bus_wr(2'd2, 32'hFFFF_FFFF);
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd1, v); check("R10 all masked", v, 32'hFFFF_FFFF);
    bus_rd(2'd0, v); check("R10 edges cleared level kept", v, 32'h2);
    @(negedge clk);
    check("R10 irq low", {31'd0, irq_out}, 32'd0);
    evt_in[1] = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_level();
    t_edge();
    t_w1c();
    t_collision();
    t_irq();
    t_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule